// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block generates the address of each beat of a four-beat burst on a synchronous memory. On a load cycle it captures a full starting address. On each later advance cycle it steps the two low address bits to the next beat, while the upper bits stay latched. A static order input selects the beat order. In linear order the low bits count up from the start and wrap modulo 4. In interleaved order the low bits are the start value XOR the beat number.

Every action is qualified by an active-high clock enable. A deselect indication ends the current burst. After a deselect, advance requests have no effect until a fresh address is loaded. The output address is produced combinationally from the latched start address, the two-bit beat counter and the order input, so it changes in the cycle that follows the edge at which a load or an advance is taken.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is 0 and no burst is open. An advance request with `advance`=1, `deselect`=0 and `clk_en`=1 leaves `addr_out` unchanged until a load has been taken.
- R2: At an edge with `clk_en`=1, `deselect`=0 and `advance`=0, the whole of `addr_in` is captured. From the next cycle `addr_out` equals `addr_in` (beat number 0), and a burst is open.
- R3: With `order_interleave`=0, after n advances since the load, `addr_out[1:0]` equals (start[1:0] + n) mod 4.
- R4: With `order_interleave`=1, after n advances since the load, `addr_out[1:0]` equals start[1:0] XOR (n mod 4).
- R5: After the fourth advance of a burst, `addr_out` is back at the starting address, and further advances repeat the same four-beat cycle.
- R6: Bits `addr_out[ADDR_W-1:2]` equal the loaded `addr_in[ADDR_W-1:2]` and do not change on an advance.
- R7: At an edge with `clk_en`=0, all other inputs are ignored, and `addr_out` and the burst state keep their values.
- R8: At an edge with `clk_en`=1 and `deselect`=1, the burst is closed and `addr_out` is held. Deselect takes priority over a load in the same cycle. Later advances have no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock qualifier, 1 = take this edge, 0 = hold everything |
| advance | input | 1 | 1 = step to next beat, 0 = load `addr_in` |
| deselect | input | 1 | 1 = close the burst and ignore advance/load |
| order_interleave | input | 1 | Static order select, 0 = linear, 1 = interleaved |
| addr_in | input | ADDR_W | Starting address captured on a load |
| addr_out | output | ADDR_W | Current beat address: latched upper bits plus the two-bit beat |

## Verification
Three requests can meet in the same cycle: a deselect, a load (`advance`=0) and a running burst. The bench drives `deselect` together with `advance`=0 at a cycle where a burst is open. It judges the result from the output: the old beat address must stay in place, and the new address must not appear. It then sends advances and expects no movement until a clean load. A second collision, `clk_en` low together with a load or an advance, is provoked in the same way and must leave the address untouched. A long pseudo-random stretch mixes all four controls and both orders against a behavioural model, checked on every clock.

// File: rtl/bas_pkg.sv
package bas_pkg;

  localparam int BEAT_W   = 2;
  localparam int BEATS    = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // linear order: start plus beat number, wrapping at the burst length
  function automatic beat_t beat_linear(beat_t start, beat_t n);
    return beat_t'(start + n);
  endfunction

  // interleaved order: bitwise exclusive-or of start and beat number
  function automatic beat_t beat_interleave(beat_t start, beat_t n);
    beat_t r;
    for (int i = 0; i < BEAT_W; i++) r[i] = start[i] ^ n[i];
    return r;
  endfunction

  function automatic beat_t beat_map(order_e ord, beat_t start, beat_t n);
    return (ord == ORD_INTERLEAVE) ? beat_interleave(start, n) : beat_linear(start, n);
  endfunction

  function automatic beat_t beat_next(beat_t n);
    return beat_t'(n + 1'b1);
  endfunction

endpackage

// File: rtl/bas_ctrl.sv
module bas_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic advance,
  input  logic deselect,
  output logic load_evt,
  output logic adv_evt,
  output logic drop_evt,
  output logic active
);

  logic active_q;

  assign drop_evt = clk_en &  deselect;
  assign load_evt = clk_en & ~deselect & ~advance;
  assign adv_evt  = clk_en & ~deselect &  advance & active_q;
  assign active   = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        active_q <= 1'b0;
    else if (drop_evt) active_q <= 1'b0;
    else if (load_evt) active_q <= 1'b1;
  end

  assert_events_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_evt, adv_evt, drop_evt}));

  assert_drop_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !active);

  assert_open_only_by_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load_evt) |=> !active);

  assert_load_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> active);

endmodule

// File: rtl/bas_beat_cnt.sv
module bas_beat_cnt
  import bas_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_evt,
  input  logic  adv_evt,
  output beat_t cnt,
  output logic  wrap_evt
);

  beat_t cnt_q;

  assign cnt      = cnt_q;
  assign wrap_evt = adv_evt && (cnt_q == beat_t'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load_evt) cnt_q <= '0;
    else if (adv_evt)  cnt_q <= beat_next(cnt_q);
  end

  assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !adv_evt) |=> $stable(cnt));

  assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt == '0));

endmodule

// File: rtl/bas_start_reg.sv
module bas_start_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] start_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_q <= '0;
    else if (load_evt) start_q <= addr_in;
  end

  assert_start_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(start_q));

endmodule

// File: rtl/bas_order.sv
module bas_order
  import bas_pkg::*;
(
  input  logic  order_interleave,
  input  beat_t start_lo,
  input  beat_t cnt,
  output beat_t beat
);

  order_e ord;

  assign ord  = order_interleave ? ORD_INTERLEAVE : ORD_LINEAR;
  assign beat = beat_map(ord, start_lo, cnt);

  always_comb begin
    if (cnt == '0) assert_beat0_is_start_R2: assert (beat == start_lo);
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              advance,
  input  logic              deselect,
  input  logic              order_interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int UP_W = ADDR_W - BEAT_W;

  logic              load_evt;
  logic              adv_evt;
  logic              drop_evt;
  logic              active;
  logic              wrap_evt;
  beat_t             cnt;
  beat_t             beat;
  logic [ADDR_W-1:0] start_q;

  bas_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .advance  (advance),
    .deselect (deselect),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .drop_evt (drop_evt),
    .active   (active)
  );

  bas_beat_cnt u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .cnt      (cnt),
    .wrap_evt (wrap_evt)
  );

  bas_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .addr_in  (addr_in),
    .start_q  (start_q)
  );

  bas_order u_order (
    .order_interleave (order_interleave),
    .start_lo         (start_q[BEAT_W-1:0]),
    .cnt              (cnt),
    .beat             (beat)
  );

  assign addr_out = {start_q[ADDR_W-1:BEAT_W], beat};

  assert_load_takes_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !deselect && !advance) |=> (addr_out == $past(addr_in)));

  assert_hold_when_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && $stable(order_interleave)) |=> $stable(addr_out));

  assert_deselect_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && deselect && $stable(order_interleave)) |=> $stable(addr_out));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !order_interleave) |=>
      (order_interleave || addr_out[BEAT_W-1:0] == beat_next($past(addr_out[BEAT_W-1:0]))));

  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

  assert_wrap_to_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (addr_out == start_q));

  assert_width_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (UP_W > 0) || !active);

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          advance = 1'b0;
  logic          deselect = 1'b0;
  logic          order_interleave = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int unsigned m_start = 0;
  int unsigned m_cnt   = 0;
  bit          m_open  = 0;
  int unsigned lcg     = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .clk_en           (clk_en),
    .advance          (advance),
    .deselect         (deselect),
    .order_interleave (order_interleave),
    .addr_in          (addr_in),
    .addr_out         (addr_out)
  );

  function automatic int unsigned model_addr();
    int unsigned s, lo;
    s = m_start % 4;
    if (order_interleave) lo = s ^ m_cnt;
    else                  lo = (s + m_cnt) % 4;
    return (m_start / 4) * 4 + lo;
  endfunction

  task automatic check(string tag);
    int unsigned exp;
    exp = model_addr();
    tests++;
    if (addr_out !== AW'(exp)) begin
      fails++;
      $display("FAIL %s: addr_out=%h expected %h", tag, addr_out, AW'(exp));
    end
  endtask

  // drive at negedge, take one edge, update model, compare at next negedge
  task automatic step(bit ce, bit adv, bit des, int unsigned a, string tag);
    clk_en = ce; advance = adv; deselect = des; addr_in = AW'(a);
    @(posedge clk);
    if (ce) begin
      if (des) m_open = 0;
      else if (!adv) begin m_start = a % (1 << AW); m_cnt = 0; m_open = 1; end
      else if (m_open) m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");
    step(1, 1, 0, 'h3FFFF, "R1 advance before load");
    step(1, 1, 0, 0, "R1 advance before load");

    // linear burst from low bits 2
    order_interleave = 1'b0;
    step(1, 0, 0, 'h2A5E, "R2 load linear");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 'h0, "R3 R5 R6 linear advance");

    // interleaved burst from low bits 3
    order_interleave = 1'b1;
    step(1, 0, 0, 'h10003, "R2 load interleaved");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 'h3FFFC, "R4 R5 R6 interleaved advance");
    step(1, 0, 0, 'h2C5, "R2 back-to-back load");
    step(1, 0, 0, 'h1F001, "R2 back-to-back load");
    step(1, 1, 0, 0, "R4 interleaved advance");

    // clock enable low with load and advance requests
    step(0, 0, 0, 'h15555, "R7 gated load ignored");
    step(0, 1, 0, 0, "R7 gated advance ignored");
    step(0, 0, 1, 0, "R7 gated deselect ignored");
    step(1, 1, 0, 0, "R7 burst still open");

    // deselect colliding with a load
    order_interleave = 1'b0;
    step(1, 0, 0, 'h00101, "R2 load linear");
    step(1, 1, 0, 0, "R3 linear advance");
    step(1, 0, 1, 'h2BEEF, "R8 deselect beats load");
    step(1, 1, 0, 0, "R8 advance after deselect");
    step(1, 1, 0, 0, "R8 advance after deselect");
    step(1, 1, 1, 0, "R8 deselect with advance");
    step(1, 0, 0, 'h2BEEF, "R2 reload after deselect");
    step(1, 1, 0, 0, "R3 linear advance");

    // mixed pseudo-random traffic in both orders
    for (int i = 0; i < 600; i++) begin
      bit ce, adv, des;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      ce  = (lcg[20:18] != 3'd0);
      adv = (lcg[23:22] != 2'd0);
      des = (lcg[27:25] == 3'd0);
      if (i == 300) order_interleave = 1'b1;
      step(ce, adv, des, lcg[31:14], "mix R3 R4 R7 R8");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule